// File: doc/BRIEF.md
# Raster Timing Generator with Register-Format Timing Bank

This block produces the horizontal sync, vertical sync, blank and display-enable strobes for a progressive raster, together with a linear address that a pixel fetch unit can use to read the frame store. Software-level mode numbers come in as pixel and line counts: active width, front porch, sync width and back porch in each direction. The block turns them into classic CRT-controller register values in which the horizontal values are in 8-pixel characters, the horizontal total is biased by −5 and the vertical total by −2, and the bits above bit 7 are packed into overflow fields. It then runs its counters from that register form.

The clock is the character clock, so one cycle is one 8-pixel character. The fetch address steps by one per character. Each line starts at a base that is the display start address for line 0 and grows by the line offset times 8 on every later line. The start address and the offset are sampled once per frame, when the raster enters vertical blanking. Panning or changing the pitch therefore never splits a visible frame.

Every output is registered. The first rising edge after reset is released shows character 0 of line 0, and each later edge shows the next raster position.

Top module: `crt_timing_gen`

## Requirements
- R1: While synchronous active-low reset is applied, de_o = 0, blank_o = 1, hsync_o = 0, vsync_o = 0 and fetch_addr_o = 0.
- R2: A line lasts floor((W + front + sync + back) / 8) characters, where W is the active width rounded up to a multiple of 8. Each clock edge after reset release presents the next character in raster order, starting at character 0 of line 0.
- R3: de_o is 1 exactly for characters below W/8 on lines below the active height. blank_o is always the inverse of de_o.
- R4: hsync_o (active high) covers characters floor((W + front)/8) up to, but not including, floor((W + front + sync)/8). That span must be 1 to 32 characters, because the sync end is compared on its low 5 bits only.
- R5: A frame lasts active + front + sync + back lines. vsync_o (active high) covers lines active + front up to, but not including, active + front + sync. The sync span must be 1 to 16 lines, because its end is compared on its low 4 bits only.
- R6: The 9-bit horizontal values and the 11-bit vertical values keep their upper bits through the overflow fields. A horizontal total of 256 or more characters, and vertical positions above 255, 511 and 1023, time the raster correctly.
- R7: On a displayed character c of line L, fetch_addr_o = (S + L × 8 × F + c) mod 2^20. S is the frame's start address and F is its 10-bit line offset.
- R8: start_addr and line_offset are sampled when the raster enters the first blank line of a frame. A change made during the active part of frame k alters nothing in frame k and applies from frame k+1. The values present during reset are the ones used for frame 0.
- R9: An active width that is not a multiple of 8 is rounded up to the next multiple of 8 for display-enable, sync placement and line length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock (one 8-pixel character per cycle) |
| rst_n | input | 1 | Synchronous active-low reset |
| h_active | input | 12 | Active width in pixels |
| h_front | input | 12 | Horizontal front porch in pixels |
| h_sync_w | input | 12 | Horizontal sync width in pixels |
| h_back | input | 12 | Horizontal back porch in pixels |
| v_active | input | 11 | Active height in lines |
| v_front | input | 11 | Vertical front porch in lines |
| v_sync_w | input | 11 | Vertical sync width in lines |
| v_back | input | 11 | Vertical back porch in lines |
| start_addr | input | 20 | Display start address, sampled once per frame |
| line_offset | input | 10 | Line pitch in units of 8 addresses, sampled once per frame |
| hsync_o | output | 1 | Horizontal sync, active high |
| vsync_o | output | 1 | Vertical sync, active high |
| blank_o | output | 1 | Blank, high outside the display region |
| de_o | output | 1 | Display enable |
| fetch_addr_o | output | 20 | Linear fetch address for the current character |

## Verification
Every raster position is compared against a model built from the porch formulas. Five modes are used:
- A compact mode with a two-line vertical sync checks the basic placement of the sync and active regions and the line-by-line address step.
- An active width that is not a multiple of 8, with odd porches, separates correct rounding up from truncation, and also separates floor-based sync placement from exact pixel counts.
- A wide mode with a horizontal total above 255 characters, a 32-character sync and a 1-line vertical sync tests the horizontal overflow bits and both edges of the short sync compares. Its start address lies near the top of the 20-bit space with the largest offset, so the address wrap is covered.
- A tall mode of more than 1024 lines with a 16-line vertical sync exercises vertical overflow bits 8, 9 and 10.
- A final run changes the start address and offset partway through frame 0. It tells a design that latches once per frame apart from one that reacts immediately.

// File: rtl/crt_pkg.sv
// crt_pkg: shared widths, hardware biases and the three views of timing data
// (raw derived values, register-format bank, decoded values) used by the
// raster timing generator. Assumes a character clock of 8 pixels.
package crt_pkg;

    localparam int HC_W    = 10;  // horizontal character counter width
    localparam int VC_W    = 12;  // vertical line counter width
    localparam int H_BIAS  = 5;   // characters per line = h_total + H_BIAS
    localparam int V_BIAS  = 2;   // lines per frame     = v_total + V_BIAS

    // Values as derived from the mode, at register precision.
    typedef struct packed {
        logic [8:0]  h_total;
        logic [8:0]  h_disp_end;
        logic [8:0]  h_sync_start;
        logic [4:0]  h_sync_end5;
        logic [10:0] v_total;
        logic [10:0] v_disp_end;
        logic [10:0] v_sync_start;
        logic [3:0]  v_sync_end4;
        logic [10:0] v_blank_start;
    } crt_raw_t;

    // Register-format bank: low bytes plus packed overflow fields.
    // h_ovf  = {h_sync_start[8], h_disp_end[8], h_total[8]}
    // v_ovf  = {v_sync_start[9], v_disp_end[9], v_total[9],
    //           v_blank_start[8], v_sync_start[8], v_disp_end[8], v_total[8]}
    // v_ext  = {v_total[10], v_blank_start[10], v_sync_start[10], v_disp_end[10]}
    typedef struct packed {
        logic [7:0] ht_lo;
        logic [7:0] hde_lo;
        logic [7:0] hss_lo;
        logic [4:0] hse;
        logic [2:0] h_ovf;
        logic [7:0] vt_lo;
        logic [7:0] vde_lo;
        logic [7:0] vss_lo;
        logic [7:0] vbs_lo;
        logic [3:0] vse;
        logic [6:0] v_ovf;
        logic       vbs_b9;
        logic [3:0] v_ext;
    } crt_bank_t;

    // Values reassembled from the bank, used by the counters.
    typedef crt_raw_t crt_dec_t;

endpackage

// File: rtl/crt_regs.sv
// crt_regs: derives register-format timing values from the pixel/line mode
// inputs, holds them in a bank with the overflow packing, and decodes the
// bank back into full-width values. Assumes mode inputs are quasi-static;
// a change is seen by the counters one cycle later.
module crt_regs
    import crt_pkg::*;
#(
    parameter int H_PIX_W  = 12,
    parameter int V_LINE_W = 11
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [H_PIX_W-1:0]  h_active,
    input  logic [H_PIX_W-1:0]  h_front,
    input  logic [H_PIX_W-1:0]  h_sync_w,
    input  logic [H_PIX_W-1:0]  h_back,
    input  logic [V_LINE_W-1:0] v_active,
    input  logic [V_LINE_W-1:0] v_front,
    input  logic [V_LINE_W-1:0] v_sync_w,
    input  logic [V_LINE_W-1:0] v_back,
    output crt_dec_t            dec_o
);

    logic [15:0] w_round, h_to_sync, h_to_end, h_sum;
    logic [15:0] v_to_sync, v_to_end;
    crt_raw_t    raw;
    crt_bank_t   bank_d, bank_q;

    // Derive the timing values in register units from the mode.
    always_comb begin
        w_round   = (16'(h_active) + 16'd7) & 16'hFFF8;
        h_to_sync = w_round + 16'(h_front);
        h_to_end  = h_to_sync + 16'(h_sync_w);
        h_sum     = h_to_end + 16'(h_back);
        v_to_sync = 16'(v_active) + 16'(v_front);
        v_to_end  = v_to_sync + 16'(v_sync_w);

        raw.h_disp_end    = 9'((w_round >> 3) - 16'd1);
        raw.h_sync_start  = 9'((h_to_sync >> 3) - 16'd1);
        raw.h_sync_end5   = 5'((h_to_end >> 3) - 16'd1);
        raw.h_total       = 9'((h_sum >> 3) - 16'(H_BIAS));
        raw.v_disp_end    = 11'(16'(v_active) - 16'd1);
        raw.v_sync_start  = 11'(v_to_sync);
        raw.v_sync_end4   = 4'(v_to_end);
        raw.v_total       = 11'(16'(v_back) + v_to_end - 16'(V_BIAS));
        raw.v_blank_start = 11'(v_active);
    end

    // Pack the derived values into low bytes and overflow fields.
    always_comb begin
        bank_d.ht_lo  = raw.h_total[7:0];
        bank_d.hde_lo = raw.h_disp_end[7:0];
        bank_d.hss_lo = raw.h_sync_start[7:0];
        bank_d.hse    = raw.h_sync_end5;
        bank_d.h_ovf  = {raw.h_sync_start[8], raw.h_disp_end[8], raw.h_total[8]};
        bank_d.vt_lo  = raw.v_total[7:0];
        bank_d.vde_lo = raw.v_disp_end[7:0];
        bank_d.vss_lo = raw.v_sync_start[7:0];
        bank_d.vbs_lo = raw.v_blank_start[7:0];
        bank_d.vse    = raw.v_sync_end4;
        bank_d.v_ovf  = {raw.v_sync_start[9], raw.v_disp_end[9], raw.v_total[9],
                         raw.v_blank_start[8], raw.v_sync_start[8],
                         raw.v_disp_end[8], raw.v_total[8]};
        bank_d.vbs_b9 = raw.v_blank_start[9];
        bank_d.v_ext  = {raw.v_total[10], raw.v_blank_start[10],
                         raw.v_sync_start[10], raw.v_disp_end[10]};
    end

    // Register bank: reloaded every cycle, including during reset.
    always_ff @(posedge clk) begin
        bank_q <= bank_d;
    end

    // Reassemble full-width values from the bank.
    always_comb begin
        dec_o.h_total       = {bank_q.h_ovf[0], bank_q.ht_lo};
        dec_o.h_disp_end    = {bank_q.h_ovf[1], bank_q.hde_lo};
        dec_o.h_sync_start  = {bank_q.h_ovf[2], bank_q.hss_lo};
        dec_o.h_sync_end5   = bank_q.hse;
        dec_o.v_total       = {bank_q.v_ext[3], bank_q.v_ovf[4], bank_q.v_ovf[0], bank_q.vt_lo};
        dec_o.v_disp_end    = {bank_q.v_ext[0], bank_q.v_ovf[5], bank_q.v_ovf[1], bank_q.vde_lo};
        dec_o.v_sync_start  = {bank_q.v_ext[1], bank_q.v_ovf[6], bank_q.v_ovf[2], bank_q.vss_lo};
        dec_o.v_sync_end4   = bank_q.vse;
        dec_o.v_blank_start = {bank_q.v_ext[2], bank_q.vbs_b9, bank_q.v_ovf[3], bank_q.vbs_lo};
    end

    // R6: wide values survive the overflow packing unchanged.
    p_roundtrip_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_o.h_total == $past(raw.h_total)) && (dec_o.v_total == $past(raw.v_total)) &&
        (dec_o.v_sync_start == $past(raw.v_sync_start)) &&
        (dec_o.v_disp_end == $past(raw.v_disp_end)) &&
        (dec_o.v_blank_start == $past(raw.v_blank_start)));

endmodule

// File: rtl/crt_counters.sv
// crt_counters: character and line counters plus the sync run flags. The
// character counter wraps at h_total + H_BIAS - 1 and the line counter at
// v_total + V_BIAS - 1. Sync ends are compared on their low bits only.
// Assumes each sync span lies within its line or frame.
module crt_counters
    import crt_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [8:0]      h_total,
    input  logic [8:0]      h_sync_start,
    input  logic [4:0]      h_sync_end5,
    input  logic [10:0]     v_total,
    input  logic [10:0]     v_sync_start,
    input  logic [3:0]      v_sync_end4,
    input  logic [10:0]     v_blank_start,
    output logic [HC_W-1:0] hc_o,
    output logic [VC_W-1:0] vc_o,
    output logic            hs_run_o,
    output logic            vs_run_o,
    output logic            line_wrap_o,
    output logic            frame_wrap_o,
    output logic            vblank_entry_o
);

    logic [HC_W-1:0] h_last;
    logic [VC_W-1:0] v_last, vc_next;

    // Last character and last line positions from the biased totals.
    always_comb begin
        h_last         = {1'b0, h_total} + HC_W'(H_BIAS - 1);
        v_last         = {1'b0, v_total} + VC_W'(V_BIAS - 1);
        line_wrap_o    = (hc_o >= h_last);
        vc_next        = (vc_o >= v_last) ? '0 : vc_o + 1'b1;
        frame_wrap_o   = line_wrap_o && (vc_o >= v_last);
        vblank_entry_o = line_wrap_o && (vc_next == {1'b0, v_blank_start});
    end

    // Character counter and horizontal sync run flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hc_o     <= '0;
            hs_run_o <= 1'b0;
        end else begin
            hc_o <= line_wrap_o ? '0 : hc_o + 1'b1;
            if (hc_o == {1'b0, h_sync_start})
                hs_run_o <= 1'b1;
            else if (hs_run_o && (hc_o[4:0] == h_sync_end5))
                hs_run_o <= 1'b0;
        end
    end

    // Line counter and vertical sync run flag, stepped at each line end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vc_o     <= '0;
            vs_run_o <= 1'b0;
        end else if (line_wrap_o) begin
            vc_o <= vc_next;
            if (vc_next == {1'b0, v_sync_start})
                vs_run_o <= 1'b1;
            else if (vs_run_o && (vc_next[3:0] == v_sync_end4))
                vs_run_o <= 1'b0;
        end
    end

    // R2: the character counter never passes the biased total.
    p_hcount_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        hc_o <= h_last);
    // R5: the line counter only moves at a line end.
    p_line_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !line_wrap_o |=> $stable(vc_o));

endmodule

// File: rtl/crt_fetch.sv
// crt_fetch: holds the per-frame start address and pitch and the current
// line base. Start and pitch are sampled on entry to vertical blank, and the
// base reloads at the frame wrap. Assumes the blank start line is non-zero.
module crt_fetch
    import crt_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int OFF_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [OFF_W-1:0]  line_offset,
    input  logic              line_wrap,
    input  logic              frame_wrap,
    input  logic              vblank_entry,
    input  logic [HC_W-1:0]   hc,
    output logic [ADDR_W-1:0] addr_o
);

    localparam int STEP_SH = 3;  // offset unit is 8 addresses

    logic [ADDR_W-1:0] start_q, line_base;
    logic [OFF_W-1:0]  off_q;
    logic [ADDR_W-1:0] step;

    // Line step in address units.
    always_comb begin
        step   = ADDR_W'({off_q, STEP_SH'(0)});
        addr_o = line_base + ADDR_W'(hc);
    end

    // Sample start and pitch on entry to vertical blank.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= start_addr;
            off_q   <= line_offset;
        end else if (vblank_entry) begin
            start_q <= start_addr;
            off_q   <= line_offset;
        end
    end

    // Line base: reload at the frame wrap, advance at every other line end.
    always_ff @(posedge clk) begin
        if (!rst_n)
            line_base <= start_addr;
        else if (frame_wrap)
            line_base <= start_q;
        else if (line_wrap)
            line_base <= line_base + step;
    end

    // R7: the line base holds for the whole of a line.
    p_base_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !line_wrap |=> $stable(line_base));
    // R8: a new frame begins at the start sampled at the last blank entry.
    p_frame_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        frame_wrap |=> (line_base == $past(start_q)));

endmodule

// File: rtl/crt_timing_gen.sv
// crt_timing_gen: raster timing generator top. Connects the register bank,
// the counters and the fetch unit, and registers all outputs together, so
// every edge presents one raster position. Assumes a character-rate clock.
module crt_timing_gen
    import crt_pkg::*;
#(
    parameter int H_PIX_W  = 12,
    parameter int V_LINE_W = 11,
    parameter int ADDR_W   = 20,
    parameter int OFF_W    = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [H_PIX_W-1:0]  h_active,
    input  logic [H_PIX_W-1:0]  h_front,
    input  logic [H_PIX_W-1:0]  h_sync_w,
    input  logic [H_PIX_W-1:0]  h_back,
    input  logic [V_LINE_W-1:0] v_active,
    input  logic [V_LINE_W-1:0] v_front,
    input  logic [V_LINE_W-1:0] v_sync_w,
    input  logic [V_LINE_W-1:0] v_back,
    input  logic [ADDR_W-1:0]   start_addr,
    input  logic [OFF_W-1:0]    line_offset,
    output logic                hsync_o,
    output logic                vsync_o,
    output logic                blank_o,
    output logic                de_o,
    output logic [ADDR_W-1:0]   fetch_addr_o
);

    crt_dec_t          dec;
    logic [HC_W-1:0]   hc;
    logic [VC_W-1:0]   vc;
    logic              hs_run, vs_run, line_wrap, frame_wrap, vblank_entry;
    logic              in_disp;
    logic [ADDR_W-1:0] addr;

    crt_regs #(.H_PIX_W(H_PIX_W), .V_LINE_W(V_LINE_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .h_active(h_active), .h_front(h_front), .h_sync_w(h_sync_w), .h_back(h_back),
        .v_active(v_active), .v_front(v_front), .v_sync_w(v_sync_w), .v_back(v_back),
        .dec_o(dec)
    );

    crt_counters u_cnt (
        .clk(clk), .rst_n(rst_n),
        .h_total(dec.h_total), .h_sync_start(dec.h_sync_start),
        .h_sync_end5(dec.h_sync_end5), .v_total(dec.v_total),
        .v_sync_start(dec.v_sync_start), .v_sync_end4(dec.v_sync_end4),
        .v_blank_start(dec.v_blank_start),
        .hc_o(hc), .vc_o(vc), .hs_run_o(hs_run), .vs_run_o(vs_run),
        .line_wrap_o(line_wrap), .frame_wrap_o(frame_wrap),
        .vblank_entry_o(vblank_entry)
    );

    crt_fetch #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_fetch (
        .clk(clk), .rst_n(rst_n),
        .start_addr(start_addr), .line_offset(line_offset),
        .line_wrap(line_wrap), .frame_wrap(frame_wrap),
        .vblank_entry(vblank_entry), .hc(hc), .addr_o(addr)
    );

    // Display region test on the current position.
    always_comb begin
        in_disp = (hc <= {1'b0, dec.h_disp_end}) && (vc <= {1'b0, dec.v_disp_end});
    end

    // Output stage: all strobes and the address for the same position.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            de_o         <= 1'b0;
            blank_o      <= 1'b1;
            hsync_o      <= 1'b0;
            vsync_o      <= 1'b0;
            fetch_addr_o <= '0;
        end else begin
            de_o         <= in_disp;
            blank_o      <= !in_disp;
            hsync_o      <= hs_run;
            vsync_o      <= vs_run;
            fetch_addr_o <= addr;
        end
    end

    // R4: neither sync pulse ever lands inside the display region.
    p_sync_outside_display_r4: assert property (@(posedge clk) disable iff (!rst_n)
        de_o |-> (!hsync_o && !vsync_o));
    // R3: blank and display enable are never high together.
    p_blank_vs_de_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(de_o && blank_o));

endmodule

// File: tb/sim_crt_timing_gen.sv
// sim_crt_timing_gen: directed bench. Each scenario task programs a mode,
// checks the reset state, then compares every raster position against a
// model computed from the porch formulas.
module sim_crt_timing_gen;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] h_active = '0, h_front = '0, h_sync_w = '0, h_back = '0;
    logic [10:0] v_active = '0, v_front = '0, v_sync_w = '0, v_back = '0;
    logic [19:0] start_addr = '0;
    logic [9:0]  line_offset = '0;
    logic        hsync_o, vsync_o, blank_o, de_o;
    logic [19:0] fetch_addr_o;

    int n_cmp = 0;
    int n_bad = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    crt_timing_gen u0 (
        .clk(clk), .rst_n(rst_n),
        .h_active(h_active), .h_front(h_front), .h_sync_w(h_sync_w), .h_back(h_back),
        .v_active(v_active), .v_front(v_front), .v_sync_w(v_sync_w), .v_back(v_back),
        .start_addr(start_addr), .line_offset(line_offset),
        .hsync_o(hsync_o), .vsync_o(vsync_o), .blank_o(blank_o), .de_o(de_o),
        .fetch_addr_o(fetch_addr_o)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: act=%0h exp=%0h", req, what, act, exp);
        end
    endtask

    // Program a mode, check reset (R1), run and compare each position.
    // At position chg_at (if >= 0) the start/offset switch to s1/o1.
    task automatic run_mode(input string tag,
                            input int xa, input int xf, input int xs, input int xb,
                            input int ya, input int yf, input int ys, input int yb,
                            input int s0, input int o0, input int frames,
                            input int chg_at, input int s1, input int o1);
        int wr, chars, lines, frame_len, hs0, hs1, vs0, vs1, dchars;
        @(negedge clk);
        rst_n = 1'b0;
        h_active = 12'(xa); h_front = 12'(xf); h_sync_w = 12'(xs); h_back = 12'(xb);
        v_active = 11'(ya); v_front = 11'(yf); v_sync_w = 11'(ys); v_back = 11'(yb);
        start_addr = 20'(s0); line_offset = 10'(o0);
        repeat (3) @(negedge clk);
        chk("R1", {tag, " reset de"},    32'(de_o), 0);
        chk("R1", {tag, " reset blank"}, 32'(blank_o), 1);
        chk("R1", {tag, " reset hsync"}, 32'(hsync_o), 0);
        chk("R1", {tag, " reset vsync"}, 32'(vsync_o), 0);
        chk("R1", {tag, " reset addr"},  32'(fetch_addr_o), 0);
        wr        = ((xa + 7) / 8) * 8;          // R9 rounding
        chars     = (wr + xf + xs + xb) / 8;
        lines     = ya + yf + ys + yb;
        frame_len = chars * lines;
        dchars    = wr / 8;
        hs0 = (wr + xf) / 8;
        hs1 = (wr + xf + xs) / 8;
        vs0 = ya + yf;
        vs1 = vs0 + ys;
        rst_n = 1'b1;
        for (int n = 0; n < frames * frame_len; n++) begin
            int f, r, ln, c, sa, oa;
            logic e_de, e_hs, e_vs;
            @(negedge clk);
            f  = n / frame_len;
            r  = n % frame_len;
            ln = r / chars;
            c  = r % chars;
            e_de = (c < dchars) && (ln < ya);
            e_hs = (c >= hs0) && (c < hs1);
            e_vs = (ln >= vs0) && (ln < vs1);
            chk("R3", {tag, " de"},    32'(de_o), 32'(e_de));
            chk("R3", {tag, " blank"}, 32'(blank_o), 32'(!e_de));
            chk("R4", {tag, " hsync (R2 line length)"}, 32'(hsync_o), 32'(e_hs));
            chk("R5", {tag, " vsync"}, 32'(vsync_o), 32'(e_vs));
            if (e_de) begin
                sa = (chg_at >= 0 && f > 0) ? s1 : s0;
                oa = (chg_at >= 0 && f > 0) ? o1 : o0;
                chk(chg_at >= 0 ? "R8" : "R7", {tag, " fetch addr"}, 32'(fetch_addr_o),
                    32'((sa + ln * oa * 8 + c) % (1 << 20)));
            end
            if (n == chg_at) begin
                start_addr  = 20'(s1);
                line_offset = 10'(o1);
            end
        end
    endtask

    // R2 R3 R4 R5 R7: compact mode, two-line vertical sync.
    task automatic t_basic();
        run_mode("basic", 32, 16, 16, 24, 4, 2, 2, 3, 'h100, 3, 2, -1, 0, 0);
    endtask

    // R9: width 27 rounds up to 32; odd porches floor to characters.
    task automatic t_round_up();
        run_mode("R9 round", 27, 13, 21, 10, 5, 1, 3, 1, 'h40, 2, 2, -1, 0, 0);
    endtask

    // R6: horizontal total over 255, 32-char hsync, 1-line vsync, R7 wrap.
    task automatic t_wide();
        run_mode("R6 wide", 2048, 64, 256, 64, 3, 1, 1, 2, 'hFFFF0, 1023, 2, -1, 0, 0);
    endtask

    // R6: over 1024 lines, bits 8/9/10 in use; R5 16-line vsync.
    task automatic t_tall();
        run_mode("R6 tall", 8, 8, 8, 24, 770, 3, 16, 300, 'h2000, 1, 2, -1, 0, 0);
    endtask

    // R8: change start/offset on line 1 of frame 0; frame 1 picks it up.
    task automatic t_pan();
        run_mode("R8 pan", 32, 16, 16, 24, 4, 2, 2, 3, 'h1000, 5, 3, 13, 'h2345, 7);
    endtask

    initial begin
        t_basic();
        t_round_up();
        t_wide();
        t_tall();
        t_pan();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_bad++;
        $display("FAIL R2 watchdog: act=timeout exp=finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule